// File: doc/BRIEF.md
# Four-Channel DMA Controller

A byte-wide DMA controller with four channels, programmed by a host through sixteen 8-bit register ports. Each channel has a 16-bit base and current address and a 16-bit base and current count. They are reached through one byte port per register. A single byte-pointer bit, shared by every channel, selects which half of the register a port access touches. Other ports set the channel mode, edit the request masks, post software requests, reset the pointer and perform a master clear. A status port reports terminal count and pending requests.

A channel is active when its request line or software request is set and its mask bit is clear. Any active channel raises the hold request. When hold is acknowledged, the lowest-numbered active channel gets an acknowledge in that same cycle. A normal channel performs one transfer per granted cycle: it drives its current address, steps the address, and decrements the count. A channel in cascade mode only has its request and acknowledge passed through. The programmed count is one less than the number of transfers. Terminal count occurs on the transfer that takes the count from zero to all ones. At that point the channel either reloads from its base registers or masks itself.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset all four mask bits are set, the byte pointer selects the low byte, and the status bits, software requests, modes and all address and count registers are zero, so hold_req stays low even with every request line high.
- R2: Port 2·n reaches channel n's address and port 2·n+1 its count. The first access after the pointer is reset uses bits 7:0 and the next uses bits 15:8. Every read or write of ports 0x0–0x7 flips the pointer, and any write to port 0xC returns it to the low byte.
- R3: A write to an address or count port loads that byte into both the base and the current register. Reads of these ports return the current register, combinationally, in the cycle host_rd is high.
- R4: Port 0xA selects a channel with bits 1:0 and writes bit 2 as its mask (1 = masked). Any write to 0xE clears all four masks. A write to 0xF copies bits 3:0 into the masks, with bit n belonging to channel n.
- R5: Port 0xB selects a channel with bits 1:0. Bits 3:2 set the transfer type: 01 pulses mem_wr, 10 pulses mem_rd, and 00 pulses neither. Bit 4 enables auto-initialize. Bit 5 makes the address decrement instead of increment. Bits 7:6 equal to 11 select cascade, and any other value gives one transfer per granted cycle.
- R6: hold_req is high whenever at least one channel has (dreq or software request) with its mask clear. While hold_ack is high, dack has exactly one bit set, the lowest-numbered active channel, in the same cycle.
- R7: In each granted non-cascade cycle, bus_addr shows the channel's current address; at the clock edge the address steps by one and the count falls by one, so a count of C yields C+1 transfers.
- R8: The transfer made with a count of zero pulses tc_pulse and sets that channel's status bit. It also clears its software request and leaves the count reading 0xFFFF. Without auto-initialize it also sets the channel's mask bit.
- R9: With auto-initialize, the terminal transfer reloads the current address and count from the base registers and leaves the mask clear.
- R10: A granted channel in cascade mode gets dack while hold_ack is high, but bus_addr stays zero, no strobe or tc_pulse occurs, and its address and count are unchanged.
- R11: Reading port 0x8 returns the terminal-count bits in bits 3:0 and the raw (dreq | software request) per channel in bits 7:4. The read clears bits 3:0 at its clock edge, but a terminal count in that same cycle sets its bit again.
- R12: A write to port 0x9 uses bits 1:0 to select a channel and writes bit 2 as its software request, which behaves like a raised dreq.
- R13: Any write to port 0xD sets all masks, returns the pointer to the low byte, and clears the status bits and software requests. Reads of ports 0x9 and 0xA–0xF return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_rd | input | 1 | Host read strobe for one cycle |
| host_addr | input | 4 | Register port number |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold acknowledge |
| bus_addr | output | 16 | Address of the current transfer, zero otherwise |
| mem_wr | output | 1 | Transfer moves data from I/O into memory |
| mem_rd | output | 1 | Transfer moves data from memory to I/O |
| tc_pulse | output | 1 | High during a channel's terminal transfer |

## Verification
hold_req, dack, bus_addr, the strobes, tc_pulse and host_rdata all follow their inputs within the same cycle. Register, pointer, mask and status effects of a write, read or transfer appear from the cycle after the rising edge that commits them. The bench changes inputs just after each rising edge. At the falling edge it compares every output with a behavioural model, then advances the model to the state that the next rising edge creates. Directed checks read registers back and count strobes only after the committing edge.

// File: rtl/dma4_ctrl.sv
module dma4_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic [3:0]  dreq,
  output logic [3:0]  dack,
  output logic        hold_req,
  input  logic        hold_ack,
  output logic [15:0] bus_addr,
  output logic        mem_wr,
  output logic        mem_rd,
  output logic        tc_pulse
);
  localparam int NCH = 4;
  localparam int RW  = 16;

  logic [RW-1:0] base_addr [NCH];
  logic [RW-1:0] base_cnt  [NCH];
  logic [RW-1:0] cur_addr  [NCH];
  logic [RW-1:0] cur_cnt   [NCH];
  logic [5:0]    mode_q    [NCH];
  logic [NCH-1:0] mask_q, sreq_q, tc_flags, auto_vec;
  logic ptr_hi;

  wire [NCH-1:0] pending = dreq | sreq_q;
  wire [NCH-1:0] active  = pending & ~mask_q;

  logic [1:0] gsel;
  always_comb begin
    gsel = 2'd0;
    for (int i = NCH - 1; i >= 0; i--)
      if (active[i]) gsel = 2'(i);
  end

  always_comb
    for (int i = 0; i < NCH; i++) auto_vec[i] = mode_q[i][2];

  wire [5:0]    gmode    = mode_q[gsel];
  wire          grant_on = hold_req & hold_ack;
  wire          xfer     = grant_on & (gmode[5:4] != 2'b11);
  wire          at_tc    = xfer & (cur_cnt[gsel] == '0);
  wire [RW-1:0] step_addr = gmode[3] ? cur_addr[gsel] - 16'd1 : cur_addr[gsel] + 16'd1;

  assign hold_req = |active;
  assign dack     = grant_on ? (4'b0001 << gsel) : 4'b0000;
  assign bus_addr = xfer ? cur_addr[gsel] : '0;
  assign mem_wr   = xfer & (gmode[1:0] == 2'b01);
  assign mem_rd   = xfer & (gmode[1:0] == 2'b10);
  assign tc_pulse = at_tc;

  wire [1:0] hch   = host_addr[2:1];
  wire       chreg = ~host_addr[3];
  wire [1:0] wch   = host_wdata[1:0];

  logic [RW-1:0] rsel;
  always_comb begin
    rsel = host_addr[0] ? cur_cnt[hch] : cur_addr[hch];
    host_rdata = 8'h00;
    if (host_rd) begin
      if (chreg)                   host_rdata = ptr_hi ? rsel[15:8] : rsel[7:0];
      else if (host_addr == 4'h8)  host_rdata = {pending, tc_flags};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_addr[i] <= '0;
        base_cnt[i]  <= '0;
        cur_addr[i]  <= '0;
        cur_cnt[i]   <= '0;
        mode_q[i]    <= '0;
      end
      mask_q   <= '1;
      sreq_q   <= '0;
      tc_flags <= '0;
      ptr_hi   <= 1'b0;
    end else begin
      if ((host_rd || host_wr) && !chreg && host_addr == 4'h8 && host_rd) tc_flags <= '0;
      if (host_wr && host_addr == 4'hD) tc_flags <= '0;

      if (xfer) begin
        cur_addr[gsel] <= step_addr;
        cur_cnt[gsel]  <= cur_cnt[gsel] - 16'd1;
        if (at_tc) begin
          tc_flags[gsel] <= 1'b1;
          sreq_q[gsel]   <= 1'b0;
          if (gmode[2]) begin
            cur_addr[gsel] <= base_addr[gsel];
            cur_cnt[gsel]  <= base_cnt[gsel];
          end else begin
            mask_q[gsel] <= 1'b1;
          end
        end
      end

      if ((host_rd || host_wr) && chreg) ptr_hi <= ~ptr_hi;

      if (host_wr) begin
        if (chreg) begin
          if (host_addr[0]) begin
            if (ptr_hi) begin
              base_cnt[hch][15:8] <= host_wdata;
              cur_cnt[hch][15:8]  <= host_wdata;
            end else begin
              base_cnt[hch][7:0] <= host_wdata;
              cur_cnt[hch][7:0]  <= host_wdata;
            end
          end else begin
            if (ptr_hi) begin
              base_addr[hch][15:8] <= host_wdata;
              cur_addr[hch][15:8]  <= host_wdata;
            end else begin
              base_addr[hch][7:0] <= host_wdata;
              cur_addr[hch][7:0]  <= host_wdata;
            end
          end
        end else begin
          case (host_addr)
            4'h9: sreq_q[wch] <= host_wdata[2];
            4'hA: mask_q[wch] <= host_wdata[2];
            4'hB: mode_q[wch] <= host_wdata[7:2];
            4'hC: ptr_hi <= 1'b0;
            4'hD: begin
              mask_q <= '1;
              sreq_q <= '0;
              ptr_hi <= 1'b0;
            end
            4'hE: mask_q <= '0;
            4'hF: mask_q <= host_wdata[3:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [3:0] host_addr,
  input logic [3:0] dack,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       mem_wr,
  input logic       mem_rd,
  input logic       tc_pulse,
  input logic [3:0] mask_q,
  input logic       ptr_hi,
  input logic [3:0] auto_vec
);
  wire mask_wr = host_wr && (host_addr == 4'hA || host_addr == 4'hD ||
                             host_addr == 4'hE || host_addr == 4'hF);

  assert_dack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_dack_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dack != 4'h0) |-> (hold_ack && hold_req));

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  assert_quiet_without_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dack == 4'h0) |-> (!mem_wr && !mem_rd && !tc_pulse));

  assert_all_masked_no_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'hF) |-> !hold_req);

  assert_ptr_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && !host_addr[3]) |=> (ptr_hi != $past(ptr_hi)));

  assert_master_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 4'hD) |=> (mask_q == 4'hF && !ptr_hi));

  assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && (dack & auto_vec) == 4'h0 && !mask_wr) |=> ((mask_q & $past(dack)) != 4'h0));

  assert_autoinit_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && (dack & auto_vec) != 4'h0 && !mask_wr) |=> ((mask_q & $past(dack)) == 4'h0));
endmodule

bind dma4_ctrl dma4_ctrl_chk u_chk (.*);

// File: tb/tb_dma4_ctrl.sv
`timescale 1ns/1ps
module tb_dma4_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, hold_ack = 1'b0;
  logic [3:0] host_addr = 4'h0, dreq = 4'h0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [3:0] dack;
  logic hold_req, mem_wr, mem_rd, tc_pulse;
  logic [15:0] bus_addr;

  always #5 clk = ~clk;

  dma4_ctrl dut (.*);

  int n_checks = 0, n_fail = 0;
  int n_mw = 0, n_mr = 0, n_tc = 0;
  bit done = 0;

  function automatic void chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // behavioural reference
  int unsigned m_ba[4], m_bc[4], m_ca[4], m_cc[4];
  bit [5:0] m_mode[4];
  bit [3:0] m_mask, m_sreq, m_stat, act;
  bit m_ptr;
  int g;
  int e_hreq, e_dack, e_ba, e_mw, e_mr, e_tc, e_rd, v;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 4'hF; m_sreq = 0; m_stat = 0; m_ptr = 0;
    end else begin
      if (mem_wr) n_mw++;
      if (mem_rd) n_mr++;
      if (tc_pulse) n_tc++;
      act = (dreq | m_sreq) & ~m_mask;
      g = -1;
      for (int i = 0; i < 4; i++) if (act[i] && g < 0) g = i;
      e_hreq = (act != 0); e_dack = 0; e_ba = 0; e_mw = 0; e_mr = 0; e_tc = 0;
      if (e_hreq != 0 && hold_ack) begin
        e_dack = 1 << g;
        if (m_mode[g][5:4] != 2'b11) begin
          e_ba = m_ca[g];
          e_mw = (m_mode[g][1:0] == 2'b01);
          e_mr = (m_mode[g][1:0] == 2'b10);
          e_tc = (m_cc[g] == 0);
        end
      end
      e_rd = 0;
      if (host_rd) begin
        if (host_addr < 8) begin
          v = host_addr[0] ? m_cc[host_addr[2:1]] : m_ca[host_addr[2:1]];
          e_rd = m_ptr ? (v >> 8) & 8'hFF : v & 8'hFF;
        end else if (host_addr == 4'h8) e_rd = {dreq | m_sreq, m_stat};
      end
      chk("R6 hold_req", int'(hold_req), e_hreq);
      chk("R6 dack", int'(dack), e_dack);
      chk("R7 bus_addr", int'(bus_addr), e_ba);
      chk("R5 mem_wr", int'(mem_wr), e_mw);
      chk("R5 mem_rd", int'(mem_rd), e_mr);
      chk("R8 tc_pulse", int'(tc_pulse), e_tc);
      chk("R3 host_rdata", int'(host_rdata), e_rd);
      // next state
      if (host_rd && host_addr == 4'h8) m_stat = 0;
      if (host_wr && host_addr == 4'hD) m_stat = 0;
      if (e_dack != 0 && m_mode[g][5:4] != 2'b11) begin
        m_ca[g] = m_mode[g][3] ? (m_ca[g] - 1) & 16'hFFFF : (m_ca[g] + 1) & 16'hFFFF;
        m_cc[g] = (m_cc[g] - 1) & 16'hFFFF;
        if (e_tc != 0) begin
          m_stat[g] = 1; m_sreq[g] = 0;
          if (m_mode[g][2]) begin m_ca[g] = m_ba[g]; m_cc[g] = m_bc[g]; end
          else m_mask[g] = 1;
        end
      end
      if (host_wr) begin
        if (host_addr < 8) begin
          if (host_addr[0]) begin
            m_bc[host_addr[2:1]] = m_ptr ? (m_bc[host_addr[2:1]] & 16'h00FF) | (host_wdata << 8)
                                         : (m_bc[host_addr[2:1]] & 16'hFF00) | host_wdata;
            m_cc[host_addr[2:1]] = m_ptr ? (m_cc[host_addr[2:1]] & 16'h00FF) | (host_wdata << 8)
                                         : (m_cc[host_addr[2:1]] & 16'hFF00) | host_wdata;
          end else begin
            m_ba[host_addr[2:1]] = m_ptr ? (m_ba[host_addr[2:1]] & 16'h00FF) | (host_wdata << 8)
                                         : (m_ba[host_addr[2:1]] & 16'hFF00) | host_wdata;
            m_ca[host_addr[2:1]] = m_ptr ? (m_ca[host_addr[2:1]] & 16'h00FF) | (host_wdata << 8)
                                         : (m_ca[host_addr[2:1]] & 16'hFF00) | host_wdata;
          end
        end
        case (host_addr)
          4'h9: m_sreq[host_wdata[1:0]] = host_wdata[2];
          4'hA: m_mask[host_wdata[1:0]] = host_wdata[2];
          4'hB: m_mode[host_wdata[1:0]] = host_wdata[7:2];
          4'hD: begin m_mask = 4'hF; m_sreq = 0; end
          4'hE: m_mask = 0;
          4'hF: m_mask = host_wdata[3:0];
          default: ;
        endcase
      end
      if ((host_rd || host_wr) && host_addr < 8) m_ptr = !m_ptr;
      if (host_wr && (host_addr == 4'hC || host_addr == 4'hD)) m_ptr = 0;
    end
  end

  // tasks start just after a rising edge
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    host_rd = 1; host_addr = a;
    @(negedge clk); d = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] lo, hi;
    int b_mw, b_mr, b_tc;
    cycles(3);
    rst_n = 1;
    cycles(1);

    // R1 reset state
    dreq = 4'hF; #1;
    chk("R1 hold_req masked after reset", int'(hold_req), 0);
    dreq = 4'h0;
    rd_reg(4'h8, lo); chk("R1 status after reset", lo, 8'h00);
    rd_reg(4'h0, lo); chk("R1 address low after reset", lo, 8'h00);
    wr_reg(4'hC, 8'h00);

    // R2 / R3 programming channel 1
    wr_reg(4'h2, 8'h99);
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h2, 8'h34);
    wr_reg(4'h2, 8'h12);
    wr_reg(4'h3, 8'h02);
    wr_reg(4'h3, 8'h00);
    rd_reg(4'h2, lo); rd_reg(4'h2, hi);
    chk("R2 address readback", {hi, lo}, 16'h1234);
    rd_reg(4'h3, lo); rd_reg(4'h3, hi);
    chk("R3 count loaded into current", {hi, lo}, 16'h0002);
    wr_reg(4'hB, 8'h45);
    wr_reg(4'hA, 8'h01);

    // R7 / R8 three single transfers, I/O to memory
    b_mw = n_mw; b_tc = n_tc;
    dreq = 4'b0010; hold_ack = 1;
    cycles(6);
    chk("R8 channel masks itself at tc", int'(hold_req), 0);
    dreq = 0; hold_ack = 0;
    chk("R7 transfer count", n_mw - b_mw, 3);
    chk("R8 one tc pulse", n_tc - b_tc, 1);
    rd_reg(4'h8, lo); chk("R8 status tc bit", lo, 8'h02);
    rd_reg(4'h8, lo); chk("R11 status cleared by read", lo, 8'h00);
    wr_reg(4'hC, 8'h00);
    rd_reg(4'h3, lo); rd_reg(4'h3, hi);
    chk("R8 residue all ones", {hi, lo}, 16'hFFFF);
    rd_reg(4'h2, lo); rd_reg(4'h2, hi);
    chk("R7 final address", {hi, lo}, 16'h1237);

    // R9 auto-initialize, decrement, memory to I/O on channel 2
    wr_reg(4'hC, 8'h00);
    wr_reg(4'h4, 8'h00); wr_reg(4'h4, 8'h01);
    wr_reg(4'h5, 8'h01); wr_reg(4'h5, 8'h00);
    wr_reg(4'hB, 8'h7A);
    wr_reg(4'hF, 8'h0B);
    b_mr = n_mr; b_tc = n_tc;
    dreq = 4'b0100; hold_ack = 1;
    cycles(5);
    chk("R9 still unmasked after reload", int'(hold_req), 1);
    dreq = 0; hold_ack = 0;
    chk("R5 mem_rd transfers", n_mr - b_mr, 5);
    chk("R9 two terminal counts", n_tc - b_tc, 2);
    wr_reg(4'hC, 8'h00);
    rd_reg(4'h4, lo); rd_reg(4'h4, hi);
    chk("R9 address after reloads", {hi, lo}, 16'h00FF);
    rd_reg(4'h5, lo); rd_reg(4'h5, hi);
    chk("R9 count after reloads", {hi, lo}, 16'h0000);

    // R6 / R11 / R12 priority with a software request
    wr_reg(4'hE, 8'h00);
    dreq = 4'b1100;
    wr_reg(4'h9, 8'h04);
    chk("R6 no dack without hold_ack", int'(dack), 0);
    chk("R12 software request raises hold", int'(hold_req), 1);
    rd_reg(4'h8, lo); chk("R11 pending and tc bits", lo, 8'hD4);
    rd_reg(4'h8, lo); chk("R11 tc bits cleared", lo, 8'hD0);
    hold_ack = 1; #1;
    chk("R6 lowest channel wins", int'(dack), 4'b0001);
    cycles(1);
    chk("R12 request dropped at tc, next channel", int'(dack), 4'b0100);
    hold_ack = 0; dreq = 0;
    cycles(1);

    // R10 cascade on channel 3
    wr_reg(4'hB, 8'hC3);
    dreq = 4'b1000; #1;
    chk("R10 cascade hold_req", int'(hold_req), 1);
    hold_ack = 1; #1;
    chk("R10 cascade dack", int'(dack), 4'b1000);
    chk("R10 cascade no address", int'(bus_addr), 0);
    cycles(3);
    wr_reg(4'hC, 8'h00);
    rd_reg(4'h6, lo); rd_reg(4'h6, hi);
    chk("R10 cascade address unchanged", {hi, lo}, 16'h0000);
    rd_reg(4'h7, lo); rd_reg(4'h7, hi);
    chk("R10 cascade count unchanged", {hi, lo}, 16'h0000);

    // R4 masks
    wr_reg(4'hA, 8'h07);
    chk("R4 single mask set", int'(hold_req), 0);
    wr_reg(4'hA, 8'h03);
    chk("R4 single mask cleared", int'(hold_req), 1);

    // R13 master clear
    wr_reg(4'h0, 8'hAA);
    wr_reg(4'hD, 8'h00);
    chk("R13 master clear masks", int'(hold_req), 0);
    rd_reg(4'hD, lo); chk("R13 temporary reads zero", lo, 8'h00);
    wr_reg(4'h0, 8'h11); wr_reg(4'h0, 8'h22);
    rd_reg(4'h0, lo); rd_reg(4'h0, hi);
    chk("R13 pointer back to low byte", {hi, lo}, 16'h2211);
    wr_reg(4'hF, 8'h07);
    chk("R4 write-all-masks unmasks channel 3", int'(hold_req), 1);
    dreq = 0; hold_ack = 0;
    cycles(2);
    summary();
  end
endmodule